// File: doc/BRIEF.md
# Programmable interval counter channel

This block is a single 16-bit down-counting timer channel. A register interface (a separate block) hands it a reload value and a 3-bit operating mode with a one-cycle write strobe. A periodic tick enable advances the count, and only while the gate input is high. A write does not start counting at once. It arms the channel, and the next qualified tick copies the reload register into the counter and starts the run.

What happens at terminal count depends on the mode. The channel can stop, reload for a periodic interrupt, or toggle its output to make a square wave. It drives an output pin and a one-cycle event pulse that marks the output changes that should raise an interrupt. The live count is brought out for latching and readback by the bus block. Counting is binary only. A count of zero stands for a period of 65536 ticks.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is idle, and `count`, `out_pin` and `event_pulse` are all 0.
- R2: A cycle with `load_req` high stores `reload_in` and the mode. Mode codes 6 and 7 are stored as 2 and 3. The write arms the channel (pending), except as given in R8 and R11, and leaves `count` unchanged. A tick in the same cycle as a write is ignored.
- R3: While pending, the first cycle with `tick_en` and `gate` both high loads `count` from the reload register and starts the run. That tick does not decrement. In mode 3 the loaded value has bit 0 cleared.
- R4: While running, each cycle with `tick_en` and `gate` high decrements `count` by 1, or by 2 in mode 3. With `gate` low or without a tick, `count` holds.
- R5: A count of 0 is a period of 65536. A running count of 0 decrements to 65535, and a reload value of 0 loads 0.
- R6: Mode 0 (interrupt on terminal count). A write drives `out_pin` low. At terminal count `out_pin` goes high, `event_pulse` pulses if the output was low, `count` reads 0 and the channel stops.
- R7: Mode 4 (software strobe). A write drives `out_pin` high. At terminal count `event_pulse` pulses, `count` reads 0 and the channel stops.
- R8: Mode 2 (rate generator). A write drives `out_pin` high. Every terminal count pulses `event_pulse` and reloads `count`. A write of mode 2 while running in mode 2 keeps the run and the current count, and the new value applies at the next reload.
- R9: Mode 3 (square wave). A write drives `out_pin` high. Each terminal count toggles `out_pin` and reloads an even count. `event_pulse` pulses only on the low-to-high toggle.
- R10: Mode 1 (one-shot). A write drives `out_pin` low. At terminal count `out_pin` goes high and `event_pulse` pulses if the output was low. The count then reloads, and later terminal counts raise no event.
- R11: Mode 5 is stored, but a write of it leaves the channel idle with `out_pin` high. `count` then holds and no event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Periodic count enable, one cycle per tick |
| gate | input | 1 | Counting allowed while high |
| load_req | input | 1 | One-cycle write strobe for reload value and mode |
| mode_in | input | 3 | Operating mode written with `load_req` |
| reload_in | input | 16 | Reload value written with `load_req` |
| count | output | 16 | Live counter value |
| out_pin | output | 1 | Channel output pin |
| event_pulse | output | 1 | One-cycle pulse on an interrupt-raising output change |

## Verification
The assertions assume that `load_req` is a clean one-cycle strobe sampled on the clock, and that `tick_en` and `gate` change only between clock edges. The property for a mode-2 rewrite expects the write to carry the code 2 or 6. The stimulus drives every input just after the falling edge, so each value is stable across the next rising edge. Writes come as single-cycle strobes. One deliberate case puts a write and a tick in the same cycle to exercise the priority in R2. The random phase uses small reload values, so that every mode reaches terminal count many times.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_PEND = 2'd1,
    RS_RUN  = 2'd2
  } run_e;

  localparam logic [2:0] MD_TERM    = 3'd0;
  localparam logic [2:0] MD_ONESHOT = 3'd1;
  localparam logic [2:0] MD_RATE    = 3'd2;
  localparam logic [2:0] MD_SQUARE  = 3'd3;
  localparam logic [2:0] MD_SWSTB   = 3'd4;
  localparam logic [2:0] MD_HWSTB   = 3'd5;

  // codes 6 and 7 alias the rate generator and square wave
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m > MD_HWSTB) ? (m - 3'd4) : m;
  endfunction

  // modes that halt at terminal count instead of reloading
  function automatic logic stops_at_tc(input logic [2:0] m);
    return (m == MD_TERM) || (m == MD_SWSTB);
  endfunction

  // output level a completed write leaves behind
  function automatic logic out_after_write(input logic [2:0] m);
    return !((m == MD_TERM) || (m == MD_ONESHOT));
  endfunction

endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_req,
  input  logic [2:0]          mode_new,
  input  logic [CW-1:0]       reload_in,
  input  logic                tick_ok,
  input  logic                term_hit,
  output run_e                run_st,
  output logic [2:0]          mode_q,
  output logic [CW-1:0]       reload_q,
  output logic                load_now,
  output logic                dec_en
);

  logic keep_run;

  // a rate-generator rewrite while running does not restart the count
  assign keep_run = (run_st == RS_RUN) && (mode_q == MD_RATE) && (mode_new == MD_RATE);
  assign load_now = !load_req && tick_ok && (run_st == RS_PEND);
  assign dec_en   = !load_req && tick_ok && (run_st == RS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_st   <= RS_IDLE;
      mode_q   <= MD_TERM;
      reload_q <= '0;
    end else if (load_req) begin
      reload_q <= reload_in;
      mode_q   <= mode_new;
      if (mode_new == MD_HWSTB) begin
        run_st <= RS_IDLE;
      end else if (!keep_run) begin
        run_st <= RS_PEND;
      end
    end else if (load_now) begin
      run_st <= RS_RUN;
    end else if (term_hit && stops_at_tc(mode_q)) begin
      run_st <= RS_IDLE;
    end
  end

endmodule

// File: rtl/pit_chan_count.sv
module pit_chan_count
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_now,
  input  logic          dec_en,
  input  logic [2:0]    mode_q,
  input  logic [CW-1:0] reload_q,
  output logic [CW-1:0] count,
  output logic          term_hit
);

  localparam logic [CW-1:0] STEP_ONE = CW'(1);
  localparam logic [CW-1:0] STEP_TWO = CW'(2);

  // square wave runs on even values only
  function automatic logic [CW-1:0] even_fix(input logic [CW-1:0] v, input logic [2:0] m);
    return (m == MD_SQUARE) ? {v[CW-1:1], 1'b0} : v;
  endfunction

  // zero is the full period, so it never sits at or below the step
  function automatic logic at_terminal(input logic [CW-1:0] c, input logic [CW-1:0] s);
    return (c != '0) && (c <= s);
  endfunction

  logic [CW-1:0] step;

  assign step     = (mode_q == MD_SQUARE) ? STEP_TWO : STEP_ONE;
  assign term_hit = dec_en && at_terminal(count, step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load_now) begin
      count <= even_fix(reload_q, mode_q);
    end else if (term_hit) begin
      count <= stops_at_tc(mode_q) ? '0 : even_fix(reload_q, mode_q);
    end else if (dec_en) begin
      count <= count - step;   // 0 wraps to the top of the full period
    end
  end

endmodule

// File: rtl/pit_chan_out.sv
module pit_chan_out
  import pit_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_req,
  input  logic [2:0] mode_new,
  input  logic [2:0] mode_q,
  input  logic       term_hit,
  output logic       out_pin,
  output logic       event_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pin     <= 1'b0;
      event_pulse <= 1'b0;
    end else begin
      event_pulse <= 1'b0;
      if (load_req) begin
        out_pin <= out_after_write(mode_new);
      end else if (term_hit) begin
        case (mode_q)
          MD_TERM, MD_ONESHOT: begin
            out_pin     <= 1'b1;
            event_pulse <= !out_pin;
          end
          MD_RATE:   event_pulse <= 1'b1;
          MD_SQUARE: begin
            out_pin     <= !out_pin;
            event_pulse <= !out_pin;
          end
          MD_SWSTB:  event_pulse <= out_pin;
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load_req,
  input  logic [2:0]    mode_in,
  input  logic [CW-1:0] reload_in,
  output logic [CW-1:0] count,
  output logic          out_pin,
  output logic          event_pulse
);

  logic          tick_ok;
  logic [2:0]    mode_new;
  logic [2:0]    mode_q;
  logic [CW-1:0] reload_q;
  logic          load_now;
  logic          dec_en;
  logic          term_hit;
  run_e          run_st;

  assign tick_ok  = tick_en && gate;
  assign mode_new = fold_mode(mode_in);

  pit_chan_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .mode_new  (mode_new),
    .reload_in (reload_in),
    .tick_ok   (tick_ok),
    .term_hit  (term_hit),
    .run_st    (run_st),
    .mode_q    (mode_q),
    .reload_q  (reload_q),
    .load_now  (load_now),
    .dec_en    (dec_en)
  );

  pit_chan_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_now (load_now),
    .dec_en   (dec_en),
    .mode_q   (mode_q),
    .reload_q (reload_q),
    .count    (count),
    .term_hit (term_hit)
  );

  pit_chan_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_req    (load_req),
    .mode_new    (mode_new),
    .mode_q      (mode_q),
    .term_hit    (term_hit),
    .out_pin     (out_pin),
    .event_pulse (event_pulse)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate,
  input logic          load_req,
  input logic [2:0]    mode_in,
  input logic [CW-1:0] count,
  input logic          out_pin,
  input logic          event_pulse,
  input run_e          run_st,
  input logic [2:0]    mode_q,
  input logic          term_hit
);

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> $stable(count));

  assert_sqw_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SQUARE && run_st == RS_RUN) |-> !count[0]);

  assert_rate_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && run_st == RS_RUN && mode_q == MD_RATE &&
     (mode_in == 3'd2 || mode_in == 3'd6)) |=> (run_st == RS_RUN));

  assert_tc_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit && mode_q == MD_TERM) |=> (run_st == RS_IDLE && out_pin && count == '0));

  assert_hw_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_HWSTB) |-> (run_st == RS_IDLE));

  assert_evt_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> out_pin);

endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate        (gate),
  .load_req    (load_req),
  .mode_in     (mode_in),
  .count       (count),
  .out_pin     (out_pin),
  .event_pulse (event_pulse),
  .run_st      (run_st),
  .mode_q      (mode_q),
  .term_hit    (term_hit)
);

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b1;
  logic        load_req = 1'b0;
  logic [2:0]  mode_in = 3'd0;
  logic [15:0] reload_in = 16'd0;
  logic [15:0] count;
  logic        out_pin;
  logic        event_pulse;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference: state 0 idle, 1 pending, 2 running
  int m_state = 0;
  int m_cnt = 0;
  int m_rel = 0;
  int m_mode = 0;
  int m_out = 0;
  int m_evt = 0;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_req(load_req), .mode_in(mode_in), .reload_in(reload_in),
    .count(count), .out_pin(out_pin), .event_pulse(event_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_rel = 0; m_mode = 0; m_out = 0; m_evt = 0;
    end else begin
      m_evt = 0;
      if (load_req) begin
        int nm;
        bit keep;
        nm = (int'(mode_in) >= 6) ? int'(mode_in) - 4 : int'(mode_in);
        keep = (m_mode == 2) && (m_state == 2) && (nm == 2);
        m_rel = int'(reload_in);
        m_mode = nm;
        if (nm == 5) m_state = 0;
        else if (!keep) m_state = 1;
        m_out = (nm <= 1) ? 0 : 1;
      end else if (tick_en && gate) begin
        if (m_state == 1) begin
          m_cnt = (m_mode == 3) ? (m_rel / 2) * 2 : m_rel;
          m_state = 2;
        end else if (m_state == 2) begin
          int stp;
          int len;
          stp = (m_mode == 3) ? 2 : 1;
          len = (m_cnt == 0) ? 65536 : m_cnt;
          if (len > stp) begin
            m_cnt = len - stp;
          end else begin
            case (m_mode)
              0: begin if (m_out == 0) m_evt = 1; m_out = 1; m_cnt = 0; m_state = 0; end
              4: begin if (m_out == 1) m_evt = 1; m_cnt = 0; m_state = 0; end
              1: begin if (m_out == 0) m_evt = 1; m_out = 1; m_cnt = m_rel; end
              2: begin m_evt = 1; m_cnt = m_rel; end
              default: begin
                m_out = 1 - m_out;
                if (m_out == 1) m_evt = 1;
                m_cnt = (m_rel / 2) * 2;
              end
            endcase
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "model count", int'(count), m_cnt);
      chk(cur_req, "model out", int'(out_pin), m_out);
      chk(cur_req, "model event", int'(event_pulse), m_evt);
    end
  end

  task automatic wr(input logic [2:0] m, input logic [15:0] v);
    @(negedge clk); #1;
    load_req = 1'b1; mode_in = m; reload_in = v;
    @(negedge clk); #1;
    load_req = 1'b0;
  endtask

  task automatic tk(input int n);
    @(negedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    #1 tick_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset count", int'(count), 0);
    chk("R1", "reset out", int'(out_pin), 0);
    chk("R1", "reset event", int'(event_pulse), 0);
    rst_n = 1'b1;

    cur_req = "R6";
    wr(3'd0, 16'd5);
    chk("R6", "out low after write", int'(out_pin), 0);
    tk(1);
    chk("R3", "pending load", int'(count), 5);
    gate = 1'b0;
    tk(3);
    chk("R4", "gate low holds", int'(count), 5);
    gate = 1'b1;
    tk(4);
    chk("R4", "count by one", int'(count), 1);
    tk(1);
    chk("R6", "tc count", int'(count), 0);
    chk("R6", "tc out", int'(out_pin), 1);
    chk("R6", "tc event", int'(event_pulse), 1);
    tk(2);
    chk("R6", "stopped count", int'(count), 0);
    chk("R6", "stopped event", int'(event_pulse), 0);

    cur_req = "R9";
    wr(3'd3, 16'd7);
    tk(1);
    chk("R9", "even load", int'(count), 6);
    tk(3);
    chk("R9", "first toggle out", int'(out_pin), 0);
    chk("R9", "first toggle event", int'(event_pulse), 0);
    chk("R9", "reload even", int'(count), 6);
    tk(3);
    chk("R9", "second toggle out", int'(out_pin), 1);
    chk("R9", "second toggle event", int'(event_pulse), 1);

    cur_req = "R11";
    wr(3'd5, 16'd7);
    tk(3);
    chk("R11", "idle count", int'(count), 6);
    chk("R11", "idle out", int'(out_pin), 1);
    chk("R11", "idle event", int'(event_pulse), 0);

    cur_req = "R5";
    wr(3'd2, 16'd0);
    tk(1);
    chk("R5", "zero load", int'(count), 0);
    tk(1);
    chk("R5", "zero wraps", int'(count), 65535);

    cur_req = "R8";
    wr(3'd5, 16'd0);
    wr(3'd2, 16'd4);
    tk(2);
    wr(3'd2, 16'd9);
    tk(1);
    chk("R8", "rewrite keeps count", int'(count), 2);
    tk(2);
    chk("R8", "new reload", int'(count), 9);
    chk("R8", "rate event", int'(event_pulse), 1);

    cur_req = "R2";
    wr(3'd7, 16'd5);
    tk(1);
    chk("R2", "code 7 as square", int'(count), 4);
    @(negedge clk); #1;
    load_req = 1'b1; tick_en = 1'b1; mode_in = 3'd0; reload_in = 16'd8;
    @(negedge clk); #1;
    load_req = 1'b0; tick_en = 1'b0;
    chk("R2", "write beats tick", int'(count), 4);
    tk(1);
    chk("R3", "load after write", int'(count), 8);

    cur_req = "R7";
    wr(3'd4, 16'd2);
    tk(3);
    chk("R7", "strobe event", int'(event_pulse), 1);
    chk("R7", "strobe count", int'(count), 0);
    tk(1);
    chk("R7", "strobe stopped", int'(count), 0);
    chk("R7", "strobe no event", int'(event_pulse), 0);

    cur_req = "R10";
    wr(3'd1, 16'd2);
    chk("R10", "oneshot out low", int'(out_pin), 0);
    tk(3);
    chk("R10", "oneshot out", int'(out_pin), 1);
    chk("R10", "oneshot event", int'(event_pulse), 1);
    chk("R10", "oneshot reload", int'(count), 2);
    tk(2);
    chk("R10", "no second event", int'(event_pulse), 0);
    chk("R10", "second reload", int'(count), 2);

    cur_req = "R2";
    lf = 32'h1badf00d;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      gate = lf[0] | lf[1];
      tick_en = lf[2];
      load_req = (lf[7:4] == 4'd0);
      mode_in = lf[10:8];
      reload_in = (lf[15:12] == 4'd0) ? 16'd0 : {12'd0, lf[19:16]};
    end
    @(negedge clk); #1;
    load_req = 1'b0; tick_en = 1'b0;
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule